// File: doc/BRIEF.md
# Calendar Real-Time Clock Core

This core keeps the time of day and the calendar date. Its input is a single-cycle tick that arrives once per second. It holds seconds, minutes, hours, day of week, day of month, month and a two-digit year, plus a seconds/minutes/hours alarm. Software reaches every count through a byte-wide register bus. The bus also carries a control register, a read-only status register and a flag register that clears when read.

Each accepted tick opens an update window of `UIP_LEAD` clock cycles. The status register shows that window, so software can see an update coming and avoid it. At the end of the window the counts advance and the update-ended flag is raised. The alarm flag is raised at the same point when the new time equals the alarm time. Each flag drives the interrupt line only while its enable bit is set.

A hold bit in the control register cancels a pending update and freezes the counts while software loads them. The control register also selects the byte format: BCD or plain binary, and 12-hour or 24-hour hours. Counts are stored internally in binary and converted at the bus, so changing the format never changes the time.

Top module: `rtc_calendar_core`

Register addresses: 0x10 seconds, 0x11 seconds alarm, 0x12 minutes, 0x13 minutes alarm, 0x14 hours, 0x15 hours alarm, 0x16 day of week, 0x17 day of month, 0x18 month, 0x19 year, 0x1A status, 0x1B control, 0x1C flags. Control bits: 7 hold, 5 alarm interrupt enable, 4 update interrupt enable, 2 binary format, 1 24-hour mode; the other control bits read 0.

## Requirements
- R1: While control bit 7 (hold) is 1, ticks are ignored and the counts do not change. Setting hold during an update window cancels that update and clears the status bit 7.
- R2: When hold is 0, an accepted tick sets status bit 7 on the next cycle. The bit stays high for `UIP_LEAD` cycles. It clears on the same edge at which the counts advance by one second.
- R3: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the date.
- R4: On a day carry, day of week advances from 1 (Sunday) to 7 (Saturday) and then returns to 1.
- R5: Day of month wraps to 1 after the last day of the month. April, June, September and November have 30 days. February has 29 days when year mod 4 is 0 and 28 days otherwise. All other months have 31 days.
- R6: Month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0.
- R7: Control bit 2 selects the byte format for reads and writes of every count and alarm register. A value of 0 selects BCD, with tens in bits 7:4 and units in bits 3:0. A value of 1 selects plain binary.
- R8: Control bit 1 set to 1 selects 24-hour hours (0 to 23). Set to 0 it selects 12-hour hours: bit 7 is 1 for PM, and bits 6:0 hold 12, 1, ..., 11.
- R9: Status register 0x1A reads bit 7 as the update-in-progress bit and bits 6:0 as the fixed value 0x20. It is 0x20 after reset.
- R10: After reset, control reads 0x02 (BCD, 24-hour). Day of week, day of month and month read 1. Year, time and alarm read 0.
- R11: Every completed update sets the update flag (flag register bit 4). The update flag drives `irq_o` only when control bit 4 is 1.
- R12: An update that lands on the alarm seconds, minutes and hours sets the alarm flag (flag register bit 5). The alarm flag drives `irq_o` only when control bit 5 is 1.
- R13: Reading register 0x1C returns `irq_o` in bit 7, the alarm flag in bit 5 and the update flag in bit 4. The read then clears both flags, so `irq_o` falls, unless an update lands on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (only used to clear the flags) |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that ticks are single-cycle pulses spaced more than `UIP_LEAD` cycles apart, so a new tick never arrives inside a running window. They also assume that no count register is written in the same cycle as an update, except where a check excludes the write cycle explicitly. The stimulus sends every tick through one task. That task waits out the whole window before the next bus access, and the time and date are loaded only while no window is open. The one exception is the abort case, where hold is deliberately set inside a window.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] A_SEC      = 8'h10;
  localparam logic [7:0] A_SEC_ALM  = 8'h11;
  localparam logic [7:0] A_MIN      = 8'h12;
  localparam logic [7:0] A_MIN_ALM  = 8'h13;
  localparam logic [7:0] A_HOUR     = 8'h14;
  localparam logic [7:0] A_HOUR_ALM = 8'h15;
  localparam logic [7:0] A_DOW      = 8'h16;
  localparam logic [7:0] A_DOM      = 8'h17;
  localparam logic [7:0] A_MON      = 8'h18;
  localparam logic [7:0] A_YEAR     = 8'h19;
  localparam logic [7:0] A_STAT     = 8'h1A;
  localparam logic [7:0] A_CTRL     = 8'h1B;
  localparam logic [7:0] A_FLAG     = 8'h1C;

  localparam int C_HOLD = 7;
  localparam int C_AIE  = 5;
  localparam int C_UIE  = 4;
  localparam int C_BIN  = 2;
  localparam int C_H24  = 1;
  localparam logic [7:0] CTRL_MASK  = 8'hB6;
  localparam logic [7:0] CTRL_RST   = 8'h02;
  localparam logic [6:0] STAT_FIXED = 7'h20;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [2:0] dow;
    logic [4:0] dom;
    logic [3:0] mon;
    logic [6:0] year;
  } cal_t;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
  } alm_t;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] t;
    logic [6:0] o;
    t = v / 7'd10;
    o = v - t * 7'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return {3'b000, b[7:4]} * 7'd10 + {3'b000, b[3:0]};
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : to_bcd(v);
  endfunction

  function automatic logic [6:0] dec(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : from_bcd(b);
  endfunction

  function automatic logic [7:0] hour_rd(input logic [4:0] h, input logic bin, input logic h24);
    logic [4:0] hh;
    if (h24) return enc({2'b00, h}, bin);
    hh = (h >= 5'd12) ? h - 5'd12 : h;
    if (hh == 5'd0) hh = 5'd12;
    return enc({2'b00, hh}, bin) | ((h >= 5'd12) ? 8'h80 : 8'h00);
  endfunction

  function automatic logic [4:0] hour_wr(input logic [7:0] b, input logic bin, input logic h24);
    logic [6:0] v;
    if (h24) begin
      v = dec(b, bin);
    end else begin
      v = dec(b & 8'h7F, bin);
      if (v == 7'd12) v = 7'd0;
      if (b[7]) v = v + 7'd12;
    end
    return v[4:0];
  endfunction

  function automatic logic [4:0] days_in_month(input logic [3:0] mon, input logic [6:0] year);
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      4'd2:                    return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
      default:                 return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int LEAD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hold_i,
  output logic uip_o,
  output logic upd_o
);
  localparam int CW = $clog2(LEAD + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign uip_o = busy_q;
  assign upd_o = busy_q && (cnt_q == CW'(1)) && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (hold_i) begin
      busy_q <= 1'b0;          // abort pending update
      cnt_q  <= '0;
    end else if (upd_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - CW'(1);
    end else if (tick_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(LEAD);
    end
  end

  assert_tick_opens_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !uip_o && !hold_i) |=> uip_o);
  assert_window_ends_on_update_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(uip_o) |-> $past(upd_o || hold_i));
  assert_hold_clears_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !uip_o);
endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  logic       wr_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       bin_i,
  input  logic       h24_i,
  output cal_t       cal_o,
  output alm_t       alm_o,
  output logic       alarm_hit_o
);
  cal_t       cur_q, nxt;
  alm_t       alm_q;
  logic       day_carry;
  logic [4:0] dim;
  logic [6:0] wdec;
  logic [4:0] whour;

  assign dim   = days_in_month(cur_q.mon, cur_q.year);
  assign wdec  = dec(wdata_i, bin_i);
  assign whour = hour_wr(wdata_i, bin_i, h24_i);

  always_comb begin
    nxt       = cur_q;
    day_carry = 1'b0;
    if (cur_q.sec >= 6'd59) begin
      nxt.sec = 6'd0;
      if (cur_q.min >= 6'd59) begin
        nxt.min = 6'd0;
        if (cur_q.hour >= 5'd23) begin
          nxt.hour  = 5'd0;
          day_carry = 1'b1;
        end else nxt.hour = cur_q.hour + 5'd1;
      end else nxt.min = cur_q.min + 6'd1;
    end else nxt.sec = cur_q.sec + 6'd1;

    if (day_carry) begin
      nxt.dow = (cur_q.dow >= 3'd7) ? 3'd1 : cur_q.dow + 3'd1;
      if (cur_q.dom >= dim) begin
        nxt.dom = 5'd1;
        if (cur_q.mon >= 4'd12) begin
          nxt.mon  = 4'd1;
          nxt.year = (cur_q.year >= 7'd99) ? 7'd0 : cur_q.year + 7'd1;
        end else nxt.mon = cur_q.mon + 4'd1;
      end else nxt.dom = cur_q.dom + 5'd1;
    end
  end

  assign alarm_hit_o = upd_i && (nxt.sec == alm_q.sec) &&
                       (nxt.min == alm_q.min) && (nxt.hour == alm_q.hour);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '{sec: 6'd0, min: 6'd0, hour: 5'd0, dow: 3'd1, dom: 5'd1, mon: 4'd1, year: 7'd0};
      alm_q <= '0;
    end else begin
      if (upd_i) cur_q <= nxt;
      if (wr_i) begin         // a write overrides the update for its own field
        case (addr_i)
          A_SEC:      cur_q.sec  <= wdec[5:0];
          A_MIN:      cur_q.min  <= wdec[5:0];
          A_HOUR:     cur_q.hour <= whour;
          A_DOW:      cur_q.dow  <= wdec[2:0];
          A_DOM:      cur_q.dom  <= wdec[4:0];
          A_MON:      cur_q.mon  <= wdec[3:0];
          A_YEAR:     cur_q.year <= wdec;
          A_SEC_ALM:  alm_q.sec  <= wdec[5:0];
          A_MIN_ALM:  alm_q.min  <= wdec[5:0];
          A_HOUR_ALM: alm_q.hour <= whour;
          default: ;
        endcase
      end
    end
  end

  assign cal_o = cur_q;
  assign alm_o = alm_q;

  assert_sec_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_i) |=> (cur_q.sec == (($past(cur_q.sec) >= 6'd59) ? 6'd0 : $past(cur_q.sec) + 6'd1)));
  assert_dow_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && day_carry && !wr_i) |=> (cur_q.dow >= 3'd1 && cur_q.dow <= 3'd7));
  assert_leap_feb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && day_carry && !wr_i && cur_q.mon == 4'd2 && cur_q.dom == 5'd28 && cur_q.year[1:0] == 2'b00)
    |=> (cur_q.dom == 5'd29 && cur_q.mon == 4'd2));
  assert_year_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_i && day_carry && cur_q.mon == 4'd12 && cur_q.dom == 5'd31 && cur_q.year == 7'd99)
    |=> (cur_q.year == 7'd0 && cur_q.mon == 4'd1));
endmodule

// File: rtl/rtc_reg_file.sv
module rtc_reg_file
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  cal_t       cal_i,
  input  alm_t       alm_i,
  input  logic       uip_i,
  input  logic       upd_i,
  input  logic       alarm_hit_i,
  output logic       hold_o,
  output logic       bin_o,
  output logic       h24_o,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  logic [7:0] ctrl_q;
  logic       uf_q, af_q, flag_rd;

  assign hold_o  = ctrl_q[C_HOLD];
  assign bin_o   = ctrl_q[C_BIN];
  assign h24_o   = ctrl_q[C_H24];
  assign flag_rd = rd_i && (addr_i == A_FLAG);
  assign irq_o   = (uf_q && ctrl_q[C_UIE]) || (af_q && ctrl_q[C_AIE]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      uf_q   <= 1'b0;
      af_q   <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_CTRL) ctrl_q <= wdata_i & CTRL_MASK;
      // set wins over a same-edge clear so no event is lost
      if (upd_i)            uf_q <= 1'b1;
      else if (flag_rd)     uf_q <= 1'b0;
      if (alarm_hit_i)      af_q <= 1'b1;
      else if (flag_rd)     af_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      A_SEC:      rdata_o = enc({1'b0, cal_i.sec}, bin_o);
      A_SEC_ALM:  rdata_o = enc({1'b0, alm_i.sec}, bin_o);
      A_MIN:      rdata_o = enc({1'b0, cal_i.min}, bin_o);
      A_MIN_ALM:  rdata_o = enc({1'b0, alm_i.min}, bin_o);
      A_HOUR:     rdata_o = hour_rd(cal_i.hour, bin_o, h24_o);
      A_HOUR_ALM: rdata_o = hour_rd(alm_i.hour, bin_o, h24_o);
      A_DOW:      rdata_o = enc({4'b0, cal_i.dow}, bin_o);
      A_DOM:      rdata_o = enc({2'b0, cal_i.dom}, bin_o);
      A_MON:      rdata_o = enc({3'b0, cal_i.mon}, bin_o);
      A_YEAR:     rdata_o = enc(cal_i.year, bin_o);
      A_STAT:     rdata_o = {uip_i, STAT_FIXED};
      A_CTRL:     rdata_o = ctrl_q;
      A_FLAG:     rdata_o = {irq_o, 1'b0, af_q, uf_q, 4'b0000};
      default:    rdata_o = 8'h00;
    endcase
  end

  assert_update_sets_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> uf_q);
  assert_alarm_sets_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_hit_i |=> af_q);
  assert_flag_read_clears_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd && !upd_i && !alarm_hit_i) |=> !irq_o);
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int UIP_LEAD = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  cal_t cal;
  alm_t alm;
  logic hold, bin, h24, uip, upd, alarm_hit;

  rtc_update_seq #(.LEAD(UIP_LEAD)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .hold_i(hold),
    .uip_o(uip), .upd_o(upd)
  );

  rtc_time_regs u_time (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd), .wr_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .bin_i(bin), .h24_i(h24),
    .cal_o(cal), .alm_o(alm), .alarm_hit_o(alarm_hit)
  );

  rtc_reg_file u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_en_i), .rd_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .cal_i(cal), .alm_i(alm),
    .uip_i(uip), .upd_i(upd), .alarm_hit_i(alarm_hit),
    .hold_o(hold), .bin_o(bin), .h24_o(h24), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  assert_hold_freezes_counts_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold && !wr_en_i) |=> $stable(cal));
endmodule

// File: tb/rtc_calendar_core_tb_top.sv
`timescale 1ns/1ps
module rtc_calendar_core_tb_top;
  localparam int LEAD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int m_sec = 0, m_min = 0, m_hr = 0, m_dow = 1, m_dom = 1, m_mon = 1, m_yr = 0;
  int a_sec = 0, a_min = 0, a_hr = 0;
  int m_ctrl = 8'h02;
  bit m_uf = 0, m_af = 0;

  always #2.5 clk = ~clk;

  rtc_calendar_core #(.UIP_LEAD(LEAD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic bit m_bin(); return m_ctrl[2]; endfunction
  function automatic bit m_h24(); return m_ctrl[1]; endfunction
  function automatic bit m_irq(); return (m_uf && m_ctrl[4]) || (m_af && m_ctrl[5]); endfunction

  function automatic logic [7:0] m_enc(int v);
    return m_bin() ? 8'(v) : 8'(((v / 10) << 4) + (v % 10));
  endfunction

  function automatic logic [7:0] m_hour(int h);
    int hh;
    if (m_h24()) return m_enc(h);
    hh = h % 12;
    if (hh == 0) hh = 12;
    return (h >= 12 ? 8'h80 : 8'h00) | m_enc(hh);
  endfunction

  function automatic int m_dim(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic m_advance();
    int t;
    t = m_hr * 3600 + m_min * 60 + m_sec + 1;
    if (t == 86400) begin
      t = 0;
      m_dow = (m_dow % 7) + 1;
      m_dom++;
      if (m_dom > m_dim(m_mon, m_yr)) begin
        m_dom = 1;
        m_mon++;
        if (m_mon > 12) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
      end
    end
    m_hr = t / 3600; m_min = (t / 60) % 60; m_sec = t % 60;
    m_uf = 1;
    if (m_sec == a_sec && m_min == a_min && m_hr == a_hr) m_af = 1;
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic set_ctrl(int c);
    m_ctrl = c & 8'hB6;
    wr(8'h1B, 8'(c));
  endtask

  task automatic set_time(int h, int m, int s);
    m_hr = h; m_min = m; m_sec = s;
    wr(8'h10, m_enc(s)); wr(8'h12, m_enc(m)); wr(8'h14, m_hour(h));
  endtask

  task automatic set_date(int dw, int dm, int mo, int yr);
    m_dow = dw; m_dom = dm; m_mon = mo; m_yr = yr;
    wr(8'h16, m_enc(dw)); wr(8'h17, m_enc(dm)); wr(8'h18, m_enc(mo)); wr(8'h19, m_enc(yr));
  endtask

  task automatic set_alarm(int h, int m, int s);
    a_hr = h; a_min = m; a_sec = s;
    wr(8'h11, m_enc(s)); wr(8'h13, m_enc(m)); wr(8'h15, m_hour(h));
  endtask

  task automatic cmp_all(string tag);
    rd_chk({tag, " R3 sec"},  8'h10, m_enc(m_sec));
    rd_chk({tag, " R3 min"},  8'h12, m_enc(m_min));
    rd_chk({tag, " R8 hour"}, 8'h14, m_hour(m_hr));
    rd_chk({tag, " R4 dow"},  8'h16, m_enc(m_dow));
    rd_chk({tag, " R5 dom"},  8'h17, m_enc(m_dom));
    rd_chk({tag, " R6 mon"},  8'h18, m_enc(m_mon));
    rd_chk({tag, " R6 year"}, 8'h19, m_enc(m_yr));
    rd_chk({tag, " R9 stat"}, 8'h1A, 8'h20);
    rd_chk({tag, " R7 ctrl"}, 8'h1B, 8'(m_ctrl));
  endtask

  // one tick; checks the update window when not held (R2, R1)
  task automatic do_tick(string tag);
    logic [7:0] d;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    rd(8'h1A, d);
    chk({tag, " R2 uip during window"}, d, m_ctrl[7] ? 8'h20 : 8'hA0);
    repeat (LEAD + 2) @(negedge clk);
    if (!m_ctrl[7]) m_advance();
    rd_chk({tag, " R2 uip after window"}, 8'h1A, 8'h20);
  endtask

  task automatic chk_flags(string tag);
    logic [7:0] exp;
    n_cmp++;
    if (irq !== m_irq()) begin
      n_bad++;
      $display("FAIL %s R11 irq_o: got %0b expected %0b", tag, irq, m_irq());
    end
    exp = {m_irq(), 1'b0, m_af, m_uf, 4'b0000};
    rd_chk({tag, " R13 flags"}, 8'h1C, exp);
    m_uf = 0; m_af = 0;
    rd_chk({tag, " R13 flags cleared"}, 8'h1C, 8'h00);
    n_cmp++;
    if (irq !== 1'b0) begin
      n_bad++;
      $display("FAIL %s R13 irq_o after read: got %0b expected 0", tag, irq);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10, R9 reset state
    cmp_all("R10 reset");
    rd_chk("R10 alarm hour reset", 8'h15, 8'h00);
    rd_chk("R10 flags reset", 8'h1C, 8'h00);

    // R3 R4 R6 R7: full rollover in BCD, 24h
    set_date(7, 31, 12, 99);
    set_time(23, 59, 58);
    set_alarm(12, 30, 0);
    cmp_all("R7 bcd load");
    do_tick("R3 t1");
    cmp_all("R3 sec step");
    do_tick("R6 t2");
    cmp_all("R6 new year");
    chk_flags("R11 uie off");

    // R5 leap and month lengths
    set_date(3, 28, 2, 24); set_time(23, 59, 59); do_tick("R5 leap"); cmp_all("R5 feb29");
    set_time(23, 59, 59); do_tick("R5 leap end"); cmp_all("R5 mar1");
    set_date(3, 28, 2, 23); set_time(23, 59, 59); do_tick("R5 nonleap"); cmp_all("R5 feb28");
    set_date(5, 30, 4, 50); set_time(23, 59, 59); do_tick("R5 april"); cmp_all("R5 may1");
    set_date(5, 30, 1, 50); set_time(23, 59, 59); do_tick("R5 jan"); cmp_all("R5 jan31");

    // R7 R8: binary, 12h
    set_ctrl(8'h04);
    set_time(23, 59, 59);
    rd_chk("R8 11pm binary", 8'h14, 8'h8B);
    do_tick("R8 midnight"); cmp_all("R8 bin 12h");
    rd_chk("R8 12am binary", 8'h14, 8'h0C);
    set_ctrl(8'h00);
    set_time(11, 59, 59); do_tick("R8 noon");
    rd_chk("R8 12pm bcd", 8'h14, 8'h92);
    set_time(13, 5, 0);
    rd_chk("R8 1pm bcd", 8'h14, 8'h81);
    cmp_all("R8 bcd 12h");
    set_ctrl(8'h06);
    rd_chk("R7 binary 24h hour", 8'h14, 8'd13);
    cmp_all("R7 binary 24h");
    set_ctrl(8'h02);
    chk_flags("R11 drain");

    // R1 hold ignores ticks
    set_ctrl(8'h82);
    do_tick("R1 held"); cmp_all("R1 held counts");
    set_ctrl(8'h02);
    // R1 abort a pending update
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    set_ctrl(8'h82);
    repeat (LEAD + 2) @(negedge clk);
    rd_chk("R1 abort uip", 8'h1A, 8'h20);
    cmp_all("R1 aborted counts");
    set_ctrl(8'h02);
    chk_flags("R1 no flags");

    // R11 R12 irq gating
    set_alarm(10, 0, 1);
    set_time(10, 0, 0);
    set_ctrl(8'h22);
    do_tick("R12 alarm hit");
    chk_flags("R12 aie on");
    set_ctrl(8'h12);
    do_tick("R11 update irq");
    chk_flags("R11 uie on");
    set_ctrl(8'h22);
    do_tick("R12 no match");
    chk_flags("R12 no alarm");
    cmp_all("R12 final");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule